// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Tracker

This block sits in front of a simple byte-addressed RAM and decides, one request per cycle, whether a store may reach the array. Several hardware contexts share the RAM. Each context can open an atomic read-modify-write sequence with a load-linked request. It then closes the sequence with a store-conditional request, which writes only if no other store has touched the reserved block in between.

The tracker holds one reservation slot per context. A slot keeps the reserved address with its four low bits forced to zero, so it covers one aligned 16-byte block. The slot's index is the owning context's ID.

Each slot is a two-state machine:
- `SLOT_IDLE`: no reservation.
- `SLOT_HELD`: a reservation is open.

Its transitions are:
- ARM: `SLOT_IDLE` to `SLOT_HELD` on a load-linked from the owning context.
- REARM: `SLOT_HELD` to `SLOT_HELD` on a further load-linked from the owner, which replaces the address.
- CONSUME: `SLOT_HELD` to `SLOT_IDLE` on any store-conditional from the owner.
- SNOOP_KILL: `SLOT_HELD` to `SLOT_IDLE` when a store that really writes hits the slot's block.

The write enable and the store-conditional result are combinational, in the same cycle as the request. Slot updates take effect at the rising edge that accepts the request. The address and data path to the RAM run alongside this block and are not part of it.

Top module: `llsc_resv_tracker`

## Requirements
- R1: After reset every slot is empty, so a store-conditional from any context fails (`sc_ok`=0, `mem_we`=0, `sc_resp_valid`=1).
- R2: The request kind is encoded on `req_kind` as 0=load, 1=load-linked, 2=plain store, 3=store-conditional. A plain store always drives `mem_we`=1 in its own cycle, whether or not any reservation exists, and never raises `sc_resp_valid`.
- R3: A load never drives `mem_we` or `sc_resp_valid`, and it neither creates nor clears a reservation.
- R4: A load-linked reserves its address with bits [3:0] cleared. A later store-conditional from the same context to any byte of that 16-byte block succeeds: in that same cycle it drives `sc_ok`=1, `mem_we`=1 and `sc_resp_valid`=1.
- R5: A store-conditional fails (`sc_ok`=0, `mem_we`=0, `sc_resp_valid`=1) when its context holds no reservation or holds one for a different 16-byte block.
- R6: A reservation belongs to its context. A store-conditional from another context to the reserved block fails, and it leaves the owner able to succeed.
- R7: Every store-conditional, whether it succeeds or fails, clears the reservation of its own context, so an immediately repeated store-conditional fails.
- R8: A load-linked from a context that already holds a reservation replaces the old block with the new one.
- R9: A plain store clears the reservation of every context on the stored 16-byte block, and leaves reservations on other blocks in place.
- R10: A successful store-conditional clears other contexts' reservations on its block. A failed one writes nothing and leaves other contexts' reservations untouched.
- R11: While `req_valid`=0, `mem_we`, `sc_resp_valid` and `sc_ok` are 0 and no reservation changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 2 | 0 load, 1 load-linked, 2 store, 3 store-conditional |
| req_addr | input | ADDR_W | Byte address of the request |
| req_ctx | input | CTX_W | ID of the requesting context |
| mem_we | output | 1 | Write enable to the RAM for this cycle's store |
| sc_resp_valid | output | 1 | A store-conditional result is presented |
| sc_ok | output | 1 | Store-conditional result: 1 success, 0 failure |

## Verification
`mem_we`, `sc_resp_valid` and `sc_ok` are due in the same cycle as the request, with no register in their path. A request's effect on the reservation slots becomes visible from the next accepted request onward. The bench drives each request just after a falling edge and samples the three outputs one time unit later, before the rising edge that commits the slot update. Its reference model is updated only after that comparison, so each expected value reflects exactly the requests committed before it.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_LL     = 2'd1,
        OP_STORE  = 2'd2,
        OP_SC     = 2'd3
    } op_kind_e;

    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;

endpackage

// File: rtl/llsc_slot.sv
module llsc_slot
    import llsc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int BLK_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              drop,
    input  logic              kill,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              held,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] BLK_MASK = ~((ADDR_W'(1) << BLK_BITS) - ADDR_W'(1));

    slot_state_e       state_q, state_d;
    logic [ADDR_W-1:0] blk_q, blk_d;
    logic [ADDR_W-1:0] req_blk;

    assign req_blk = req_addr & BLK_MASK;

    always_comb begin
        state_d = state_q;
        blk_d   = blk_q;
        unique case (state_q)
            SLOT_IDLE: begin
                if (arm) begin              // ARM
                    state_d = SLOT_HELD;
                    blk_d   = req_blk;
                end
            end
            SLOT_HELD: begin
                if (arm) begin              // REARM
                    blk_d = req_blk;
                end else if (drop || kill) begin  // CONSUME / SNOOP_KILL
                    state_d = SLOT_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
            blk_q   <= '0;
        end else begin
            state_q <= state_d;
            blk_q   <= blk_d;
        end
    end

    always_comb begin
        held = (state_q == SLOT_HELD);
        hit  = held && (blk_q == req_blk);
    end

endmodule

// File: rtl/llsc_decide.sv
module llsc_decide
    import llsc_pkg::*;
#(
    parameter int CTX_W = 2
) (
    input  logic                 req_valid,
    input  op_kind_e             req_op,
    input  logic [CTX_W-1:0]     req_ctx,
    input  logic [(1<<CTX_W)-1:0] hit,
    output logic                 mem_we,
    output logic                 sc_resp_valid,
    output logic                 sc_ok,
    output logic [(1<<CTX_W)-1:0] arm,
    output logic [(1<<CTX_W)-1:0] drop,
    output logic [(1<<CTX_W)-1:0] kill
);
    localparam int NUM_CTX = 1 << CTX_W;

    logic [NUM_CTX-1:0] ctx_sel;

    assign ctx_sel = NUM_CTX'(1) << req_ctx;

    always_comb begin
        mem_we        = 1'b0;
        sc_resp_valid = 1'b0;
        sc_ok         = 1'b0;
        arm           = '0;
        drop          = '0;
        kill          = '0;
        if (req_valid) begin
            unique case (req_op)
                OP_LOAD: begin
                end
                OP_LL: begin
                    arm = ctx_sel;
                end
                OP_STORE: begin
                    mem_we = 1'b1;
                    kill   = hit;
                end
                OP_SC: begin
                    sc_resp_valid = 1'b1;
                    sc_ok         = hit[req_ctx];
                    mem_we        = hit[req_ctx];
                    drop          = ctx_sel;
                    kill          = hit[req_ctx] ? hit : '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/llsc_resv_tracker.sv
module llsc_resv_tracker
    import llsc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CTX_W    = 2,
    parameter int BLK_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CTX_W-1:0]  req_ctx,
    output logic              mem_we,
    output logic              sc_resp_valid,
    output logic              sc_ok
);
    localparam int NUM_CTX = 1 << CTX_W;

    logic [NUM_CTX-1:0] slot_hit;
    logic [NUM_CTX-1:0] slot_held;
    logic [NUM_CTX-1:0] slot_arm;
    logic [NUM_CTX-1:0] slot_drop;
    logic [NUM_CTX-1:0] slot_kill;

    llsc_decide #(
        .CTX_W (CTX_W)
    ) u_decide (
        .req_valid     (req_valid),
        .req_op        (op_kind_e'(req_kind)),
        .req_ctx       (req_ctx),
        .hit           (slot_hit),
        .mem_we        (mem_we),
        .sc_resp_valid (sc_resp_valid),
        .sc_ok         (sc_ok),
        .arm           (slot_arm),
        .drop          (slot_drop),
        .kill          (slot_kill)
    );

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_slot
        llsc_slot #(
            .ADDR_W   (ADDR_W),
            .BLK_BITS (BLK_BITS)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm      (slot_arm[g]),
            .drop     (slot_drop[g]),
            .kill     (slot_kill[g]),
            .req_addr (req_addr),
            .held     (slot_held[g]),
            .hit      (slot_hit[g])
        );
    end

endmodule

// File: rtl/llsc_resv_tracker_chk.sv
module llsc_resv_tracker_chk #(
    parameter int ADDR_W   = 32,
    parameter int CTX_W    = 2,
    parameter int BLK_BITS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic [ADDR_W-1:0] req_addr,
    input logic [CTX_W-1:0]  req_ctx,
    input logic              mem_we,
    input logic              sc_resp_valid,
    input logic              sc_ok
);
    localparam logic [ADDR_W-1:0] BLK_MASK = ~((ADDR_W'(1) << BLK_BITS) - ADDR_W'(1));

    logic              past_ok;
    logic [ADDR_W-1:0] cur_blk;
    logic              is_ld, is_ll, is_st, is_sc;

    assign cur_blk = req_addr & BLK_MASK;
    assign is_ld   = req_valid && (req_kind == 2'd0);
    assign is_ll   = req_valid && (req_kind == 2'd1);
    assign is_st   = req_valid && (req_kind == 2'd2);
    assign is_sc   = req_valid && (req_kind == 2'd3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_LOAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        is_ld |-> (!mem_we && !sc_resp_valid)); // R3

    AST_STORE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        is_st |-> (mem_we && !sc_resp_valid)); // R2

    AST_SC_GATED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        is_sc |-> (sc_resp_valid && (mem_we == sc_ok))); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!mem_we && !sc_resp_valid && !sc_ok)); // R11

    AST_LL_SC_PAIR_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(is_ll) && is_sc && (req_ctx == $past(req_ctx))
         && (cur_blk == $past(cur_blk))) |-> sc_ok); // R4

    AST_SC_REPEAT_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(is_sc) && is_sc && (req_ctx == $past(req_ctx))) |-> !sc_ok); // R7

endmodule

bind llsc_resv_tracker llsc_resv_tracker_chk #(
    .ADDR_W   (ADDR_W),
    .CTX_W    (CTX_W),
    .BLK_BITS (BLK_BITS)
) u_chk (.*);

// File: tb/llsc_resv_tracker_test.sv
module llsc_resv_tracker_test;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_ctx = '0;
    logic        mem_we, sc_resp_valid, sc_ok;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    bit          mv [NC];
    logic [31:0] ma [NC];

    always #(CLK_PERIOD/2) clk = ~clk;

    llsc_resv_tracker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_ctx(req_ctx), .mem_we(mem_we),
        .sc_resp_valid(sc_resp_valid), .sc_ok(sc_ok)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic issue(input int kind, input logic [31:0] addr, input int ctx,
                         input string tag, input bit vld = 1'b1);
        logic [31:0] blk;
        bit e_we, e_rv, e_ok;
        @(negedge clk);
        req_valid = vld;
        req_kind  = 2'(kind);
        req_addr  = addr;
        req_ctx   = 2'(ctx);
        #1;
        blk  = addr & 32'hFFFF_FFF0;
        e_ok = vld && kind == 3 && mv[ctx] && ma[ctx] == blk;
        e_rv = vld && kind == 3;
        e_we = vld && (kind == 2 || e_ok);
        chk(tag, "mem_we", mem_we, e_we);
        chk(tag, "sc_resp_valid", sc_resp_valid, e_rv);
        chk(tag, "sc_ok", sc_ok, e_ok);
        if (vld) begin
            if (kind == 1) begin
                mv[ctx] = 1'b1;
                ma[ctx] = blk;
            end
            if (e_we) begin
                for (int i = 0; i < NC; i++)
                    if (mv[i] && ma[i] == blk) mv[i] = 1'b0;
            end
            if (kind == 3) mv[ctx] = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NC; i++) begin
            mv[i] = 1'b0;
            ma[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        for (int c = 0; c < NC; c++) issue(3, 32'h40, c, "R1");

        // R2: plain store on empty table writes
        issue(2, 32'h1234, 1, "R2");

        // R3 / R4: loads do not disturb; SC within same block succeeds
        issue(1, 32'h100, 0, "R4");
        issue(0, 32'h100, 0, "R3");
        issue(0, 32'h104, 1, "R3");
        issue(3, 32'h10C, 0, "R4");

        // R5: other block, no reservation
        issue(1, 32'h200, 1, "R5");
        issue(3, 32'h210, 1, "R5");
        issue(3, 32'h300, 2, "R5");

        // R6: ownership
        issue(1, 32'h400, 2, "R6");
        issue(3, 32'h400, 3, "R6");
        issue(3, 32'h404, 2, "R6");

        // R7: SC consumes own reservation
        issue(1, 32'h500, 0, "R7");
        issue(3, 32'h500, 0, "R7");
        issue(3, 32'h500, 0, "R7");
        issue(1, 32'h600, 1, "R7");
        issue(3, 32'h700, 1, "R7");
        issue(3, 32'h600, 1, "R7");

        // R8: LL replaces
        issue(1, 32'h800, 3, "R8");
        issue(1, 32'h900, 3, "R8");
        issue(3, 32'h800, 3, "R8");
        issue(1, 32'h800, 3, "R8");
        issue(1, 32'h900, 3, "R8");
        issue(3, 32'h90F, 3, "R8");

        // R9: plain store clears matching block only
        issue(1, 32'hA00, 0, "R9");
        issue(1, 32'hA08, 1, "R9");
        issue(1, 32'hB00, 2, "R9");
        issue(2, 32'hA0C, 3, "R9");
        issue(3, 32'hA00, 0, "R9");
        issue(3, 32'hA04, 1, "R9");
        issue(3, 32'hB00, 2, "R9");

        // R10: successful SC kills others, failed SC does not
        issue(1, 32'hC00, 0, "R10");
        issue(1, 32'hC00, 1, "R10");
        issue(3, 32'hC00, 0, "R10");
        issue(3, 32'hC00, 1, "R10");
        issue(1, 32'hD00, 2, "R10");
        issue(1, 32'hD00, 3, "R10");
        issue(3, 32'hE00, 3, "R10");
        issue(3, 32'hD00, 2, "R10");

        // R11: no effect while req_valid is low
        issue(1, 32'hF00, 0, "R11");
        issue(3, 32'hF00, 0, "R11", 1'b0);
        issue(2, 32'hF00, 1, "R11", 1'b0);
        issue(1, 32'h123, 0, "R11", 1'b0);
        issue(3, 32'hF04, 0, "R11");

        // mixed traffic over a few blocks
        for (int n = 0; n < 600; n++) begin
            int k;
            int c;
            logic [31:0] a;
            bit v;
            k = int'($urandom_range(3, 0));
            c = int'($urandom_range(NC-1, 0));
            a = 32'h2000 + ($urandom_range(3, 0) << 4) + $urandom_range(15, 0);
            v = ($urandom_range(7, 0) != 0);
            case (k)
                0:       issue(k, a, c, "R3", v);
                1:       issue(k, a, c, "R8", v);
                2:       issue(k, a, c, "R9", v);
                default: issue(k, a, c, "R10", v);
            endcase
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule